// File: doc/BRIEF.md
# Byte-Wide Multiplexed Register Bus Slave

This block lets an external host reach a bank of up to sixteen 8-bit registers over a narrow parallel bus. Eight shared lines carry either a register index or a data byte. A select line tells the slave which of the two the host is sending. Every access takes two bus cycles. First the host writes an index with the select line high. Then it performs one data read or one data write with the select line low, and that data cycle targets the latched index.

All host controls are asynchronous to the internal clock, so the block synchronizes them first. It acts on the falling edge of a qualified read or write strobe and forwards each data cycle to a generic register port as a one-clock strobe. An active-low ready output tells the host when read data is valid or when a write has been taken. The highest index holds a read-only revision byte that the block answers by itself. An active-low interrupt line mirrors an internal interrupt-pending input.

Top module: `bytebus_reg_slave`

## Requirements
- R1: After reset, rdy_no is 1, bus_d_oe_o is 0, reg_wr_o and reg_rd_o are 0 and reg_idx_o is 0.
- R2: A write strobe with cs_ni low and sel_idx_i high loads bus_d_i[3:0] into the index shown on reg_idx_o. bus_d_i[7:4] is ignored, and no register strobe is produced.
- R3: A write strobe with cs_ni low and sel_idx_i low produces exactly one reg_wr_o pulse of one clock, with reg_idx_o at the latched index and reg_wdata_o equal to the bus byte.
- R4: A read strobe with cs_ni low and sel_idx_i low produces exactly one reg_rd_o pulse. The reg_rdata_i byte sampled during that pulse is presented on bus_d_o, and rdy_no goes low on the next clock edge, no more than three edges after the strobe falls.
- R5: Index 0xF is read-only. A read there returns the REV_ID parameter (default 0x3C) with no reg_rd_o pulse. A write there produces no reg_wr_o pulse.
- R6: bus_d_oe_o is 1 exactly when cs_ni, rd_ni and sel_idx_i are all 0.
- R7: Strobes while cs_ni is high are ignored. No register strobe is produced and the index does not change.
- R8: The latched index persists across data cycles, so repeated data cycles reach the same register until the next index write.
- R9: rdy_no returns to 1 within four clocks after both rd_ni and wr_ni are high.
- R10: irq_no is always the inverse of irq_pend_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_d_i | input | 8 | Shared bus lines, inbound |
| bus_d_o | output | 8 | Shared bus lines, outbound read byte |
| bus_d_oe_o | output | 1 | Drive enable for bus_d_o; 0 means high impedance |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| sel_idx_i | input | 1 | 1: bus carries an index, 0: bus carries data |
| rdy_no | output | 1 | Ready, active low |
| irq_no | output | 1 | Interrupt, active low |
| irq_pend_i | input | 1 | Internal interrupt pending |
| reg_idx_o | output | 4 | Register index to the register file |
| reg_wr_o | output | 1 | One-clock register write strobe |
| reg_wdata_o | output | 8 | Register write byte |
| reg_rd_o | output | 1 | One-clock register read strobe |
| reg_rdata_i | input | 8 | Register read byte, valid while reg_rd_o is high |

## Verification
The interrupt path and the read-completion path can change in the same clock. The bench raises irq_pend_i on the same falling edge where it drops the read strobe. It then checks that irq_no follows at once, while rdy_no asserts later with the right byte on bus_d_o. Neither event may delay or corrupt the other.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
  typedef enum logic [1:0] {ACC_NONE, ACC_IDX, ACC_WR, ACC_RD} acc_e;
endpackage

// File: rtl/bbs_sync.sv
module bbs_sync #(
  parameter int               WIDTH   = 4,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/bbs_access_decode.sv
module bbs_access_decode
  import bbs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_s_i,
  input  logic rd_n_s_i,
  input  logic wr_n_s_i,
  input  logic sel_idx_s_i,
  output acc_e acc_o,
  output logic idle_o
);
  localparam int NSTRB = 2;  // 0: write, 1: read

  logic [NSTRB-1:0] strb_s;
  logic [NSTRB-1:0] fall;

  assign strb_s = {rd_n_s_i, wr_n_s_i};

  for (genvar g = 0; g < NSTRB; g++) begin : g_edge
    logic prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b1;
      else         prev_q <= strb_s[g];
    end
    assign fall[g] = prev_q & ~strb_s[g];
  end

  assign idle_o = &strb_s;

  always_comb begin
    acc_o = ACC_NONE;
    if (!cs_n_s_i) begin
      if (fall[0])                     acc_o = sel_idx_s_i ? ACC_IDX : ACC_WR;
      else if (fall[1] && !sel_idx_s_i) acc_o = ACC_RD;
    end
  end
endmodule

// File: rtl/bbs_index_reg.sv
module bbs_index_reg
  import bbs_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  acc_e             acc_i,
  input  logic [IDX_W-1:0] idx_d_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             ro_o
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               idx_q <= '0;
    else if (acc_i == ACC_IDX) idx_q <= idx_d_i;
  end

  assign idx_o = idx_q;
  assign ro_o  = &idx_q;  // top index is the revision byte
endmodule

// File: rtl/bbs_read_path.sv
module bbs_read_path
  import bbs_pkg::*;
#(
  parameter int              DATA_W = 8,
  parameter logic [DATA_W-1:0] REV_ID = 8'h3C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  acc_e              acc_i,
  input  logic              ro_i,
  input  logic              idle_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o
);
  logic [DATA_W-1:0] rdata_q;
  logic              ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      ready_q <= 1'b0;
    end else begin
      unique case (acc_i)
        ACC_RD: begin
          rdata_q <= ro_i ? REV_ID : rdata_i;
          ready_q <= 1'b1;
        end
        ACC_WR, ACC_IDX: ready_q <= 1'b1;
        default: if (idle_i) ready_q <= 1'b0;
      endcase
    end
  end

  assign rdata_o = rdata_q;
  assign ready_o = ready_q;
endmodule

// File: rtl/bytebus_reg_slave.sv
module bytebus_reg_slave
  import bbs_pkg::*;
#(
  parameter int              DATA_W      = 8,
  parameter int              IDX_W       = 4,
  parameter int              SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] REV_ID    = 8'h3C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] bus_d_i,
  output logic [DATA_W-1:0] bus_d_o,
  output logic              bus_d_oe_o,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic              sel_idx_i,
  output logic              rdy_no,
  output logic              irq_no,
  input  logic              irq_pend_i,
  output logic [IDX_W-1:0]  reg_idx_o,
  output logic              reg_wr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_rd_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  localparam int NCTL = 4;
  localparam logic [NCTL-1:0] CTL_RST = 4'b1110;  // strobes idle high, select low

  logic [NCTL-1:0] ctl_s;
  acc_e            acc;
  logic            idle, ro, ready;
  logic [IDX_W-1:0] idx;

  bbs_sync #(.WIDTH(NCTL), .STAGES(SYNC_STAGES), .RST_VAL(CTL_RST)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({cs_ni, rd_ni, wr_ni, sel_idx_i}),
    .q_o (ctl_s)
  );

  bbs_access_decode u_dec (
    .clk_i, .rst_ni,
    .cs_n_s_i    (ctl_s[3]),
    .rd_n_s_i    (ctl_s[2]),
    .wr_n_s_i    (ctl_s[1]),
    .sel_idx_s_i (ctl_s[0]),
    .acc_o       (acc),
    .idle_o      (idle)
  );

  bbs_index_reg #(.IDX_W(IDX_W)) u_idx (
    .clk_i, .rst_ni,
    .acc_i   (acc),
    .idx_d_i (bus_d_i[IDX_W-1:0]),
    .idx_o   (idx),
    .ro_o    (ro)
  );

  bbs_read_path #(.DATA_W(DATA_W), .REV_ID(REV_ID)) u_rd (
    .clk_i, .rst_ni,
    .acc_i   (acc),
    .ro_i    (ro),
    .idle_i  (idle),
    .rdata_i (reg_rdata_i),
    .rdata_o (bus_d_o),
    .ready_o (ready)
  );

  assign reg_idx_o   = idx;
  assign reg_wr_o    = (acc == ACC_WR) && !ro;
  assign reg_rd_o    = (acc == ACC_RD) && !ro;
  assign reg_wdata_o = bus_d_i;
  // raw pins: drive window follows the host's own controls
  assign bus_d_oe_o  = ~cs_ni & ~rd_ni & ~sel_idx_i;
  assign rdy_no      = ~ready;
  assign irq_no      = ~irq_pend_i;
endmodule

// File: rtl/bbs_checker.sv
module bbs_checker #(
  parameter int IDX_W  = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_wr_o,
  input logic             reg_rd_o,
  input logic [IDX_W-1:0] reg_idx_o,
  input logic             rdy_no
);
  AST_WR_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> !reg_wr_o);  // R3
  AST_RD_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_o |=> !reg_rd_o);  // R4
  AST_RDY_AFTER_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_o |=> !rdy_no);  // R4
  AST_RO_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> reg_idx_o != {IDX_W{1'b1}});  // R5
  AST_RO_NO_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_o |-> reg_idx_o != {IDX_W{1'b1}});  // R5
  AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_o || reg_rd_o) |=> $stable(reg_idx_o));  // R8
endmodule

bind bytebus_reg_slave bbs_checker #(.IDX_W(IDX_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .reg_wr_o  (reg_wr_o),
  .reg_rd_o  (reg_rd_o),
  .reg_idx_o (reg_idx_o),
  .rdy_no    (rdy_no)
);

// File: tb/tb_bytebus_reg_slave.sv
`timescale 1ns/1ps
module tb_bytebus_reg_slave;
  localparam logic [7:0] REV = 8'h3C;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] bus_d_i = '0;
  logic [7:0] bus_d_o;
  logic       bus_d_oe_o;
  logic       cs_ni = 1'b1, rd_ni = 1'b1, wr_ni = 1'b1, sel_idx_i = 1'b0;
  logic       rdy_no, irq_no;
  logic       irq_pend_i = 1'b0;
  logic [3:0] reg_idx_o;
  logic       reg_wr_o, reg_rd_o;
  logic [7:0] reg_wdata_o, reg_rdata_i;

  logic [7:0] mem [16];
  int wr_cnt = 0, rd_cnt = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  bytebus_reg_slave dut (.*);

  assign reg_rdata_i = mem[reg_idx_o];

  always @(posedge clk_i) begin
    if (reg_wr_o) begin mem[reg_idx_o] <= reg_wdata_o; wr_cnt <= wr_cnt + 1; end
    if (reg_rd_o) rd_cnt <= rd_cnt + 1;
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic sel, logic [7:0] d, logic cs_n);
    @(negedge clk_i); cs_ni = cs_n; sel_idx_i = sel; bus_d_i = d;
    @(negedge clk_i); wr_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    wr_ni = 1'b1;
    @(negedge clk_i); cs_ni = 1'b1;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic t_index(logic [7:0] d, logic [3:0] exp);
    int w0 = wr_cnt;
    bus_write(1'b1, d, 1'b0);
    check("R2 index", {4'h0, reg_idx_o}, {4'h0, exp});
    check("R2 no strobe", 8'(wr_cnt - w0), 8'd0);
  endtask

  task automatic t_data_write(logic [7:0] d, logic [3:0] idx, int exp_pulses);
    int w0 = wr_cnt;
    bus_write(1'b0, d, 1'b0);
    check("R3 pulse count", 8'(wr_cnt - w0), 8'(exp_pulses));
    if (exp_pulses != 0) check("R3 data", mem[idx], d);
    check("R9 ready released", {7'h0, rdy_no}, 8'h01);
  endtask

  task automatic t_read(logic [7:0] exp, int exp_pulses, logic irq_set);
    int r0 = rd_cnt;
    int waited = 0;
    @(negedge clk_i); cs_ni = 1'b0; sel_idx_i = 1'b0;
    @(negedge clk_i); rd_ni = 1'b0; irq_pend_i = irq_set;
    #1 check("R6 oe on", {7'h0, bus_d_oe_o}, 8'h01);
    check("R10 irq", {7'h0, irq_no}, {7'h0, ~irq_set});
    while (rdy_no && waited < 8) begin @(negedge clk_i); waited++; end
    check("R4 ready latency", 8'(waited <= 3), 8'd1);
    check("R4 data", bus_d_o, exp);
    check("R4 pulse count", 8'(rd_cnt - r0), 8'(exp_pulses));
    rd_ni = 1'b1;
    #1 check("R6 oe off", {7'h0, bus_d_oe_o}, 8'h00);
    @(negedge clk_i); cs_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R9 ready released", {7'h0, rdy_no}, 8'h01);
  endtask

  task automatic t_cs_high;
    int w0 = wr_cnt;
    logic [3:0] i0 = reg_idx_o;
    bus_write(1'b1, 8'h03, 1'b1);
    check("R7 index kept", {4'h0, reg_idx_o}, {4'h0, i0});
    bus_write(1'b0, 8'hEE, 1'b1);
    check("R7 no write", 8'(wr_cnt - w0), 8'd0);
  endtask

  task automatic t_oe_index_phase;
    @(negedge clk_i); cs_ni = 1'b0; sel_idx_i = 1'b1; rd_ni = 1'b0;
    #1 check("R6 oe index phase", {7'h0, bus_d_oe_o}, 8'h00);
    @(negedge clk_i); rd_ni = 1'b1; cs_ni = 1'b1; sel_idx_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'(i);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 rdy", {7'h0, rdy_no}, 8'h01);
    check("R1 oe", {7'h0, bus_d_oe_o}, 8'h00);
    check("R1 strobes", {6'h0, reg_wr_o, reg_rd_o}, 8'h00);
    check("R1 index", {4'h0, reg_idx_o}, 8'h00);
    check("R10 irq idle", {7'h0, irq_no}, 8'h01);

    t_index(8'hA7, 4'h7);
    t_data_write(8'h5A, 4'h7, 1);
    t_data_write(8'hC3, 4'h7, 1);
    check("R8 index persists", {4'h0, reg_idx_o}, 8'h07);
    t_read(8'hC3, 1, 1'b1);
    t_read(8'hC3, 1, 1'b0);
    t_index(8'h02, 4'h2);
    t_data_write(8'h11, 4'h2, 1);
    t_index(8'h09, 4'h9);
    t_data_write(8'h99, 4'h9, 1);
    t_index(8'h02, 4'h2);
    t_read(8'h11, 1, 1'b0);
    t_index(8'h0F, 4'hF);
    t_data_write(8'h77, 4'hF, 0);
    t_read(REV, 0, 1'b0);
    t_cs_high;
    t_oe_index_phase;

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule